// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Sequencer

This block starts an interrupt handler and later returns from it. It watches a vector of pending interrupt lines and keeps only those enabled by its active mask. When it is idle and a save level is free, it takes the lowest-numbered enabled line and acknowledges it. It then pushes the interrupted context (environment, frame pointer, stack pointer, program counter and active mask) onto an internal save stack. Next it reads the eight-word, 32-byte vector entry of that interrupt from memory through a simple word-read port.

Once the last word has been read, the block presents a new handler context for one cycle. The environment, frame base and handler address come from the entry, and the stack pointer is the frame base plus 16 bytes. The block then narrows its mask to the entry's mask field ANDed with the mask already in force. On an exit request it pops the newest saved context, presents it for one cycle and puts the saved mask back. In the next idle cycle it checks again for pending lines under the restored mask, so an interrupt that was held back is dispatched at once.

Top module: `vec_irq_dispatch`

## Requirements
- R1: After reset `busy`, `ld_valid`, `rd_req` and `irq_ack` are low and `mask_out` is all ones.
- R2: While idle, with fewer than 4 saved levels, if `irq_pend & mask_out` is non-zero, `irq_ack` in that same cycle is one-hot on the lowest set bit of that AND. Bit i stands for interrupt i.
- R3: No line is acknowledged when `irq_pend & mask_out` is zero, nor while `busy` is high.
- R4: After an acknowledge of interrupt n, exactly 8 reads are granted, in order, at `VEC_BASE + 32*n + 4*k` for k = 0..7. `rd_addr` and `rd_req` hold steady while `rd_gnt` is low.
- R5: Entry word 0 is the environment, word 1 the frame base, word 2 the handler program counter and word 3 the mask (low NUM_IRQ bits are used). Words 4 to 7 are read but do not affect any output.
- R6: In the cycle after the eighth grant, `ld_valid`=1 and `ld_restore`=0 for one cycle. `ld_env`, `ld_fp` and `ld_pc` carry words 0, 1 and 2, and `ld_sp` equals word 1 plus 16.
- R7: From the cycle after that load, `mask_out` equals entry word 3 ANDed with the mask in force before the load.
- R8: `exit_req` while idle with at least one saved level gives `ld_valid`=1 and `ld_restore`=1 in the next cycle. The `ld_*` outputs then carry the `run_*` values sampled in the acknowledge cycle of the newest level, and `mask_out` returns to that level's saved mask one cycle later.
- R9: `exit_req` with no saved level produces no load and leaves `mask_out` unchanged.
- R10: At most 4 levels nest. With 4 saved levels, no line is acknowledged.
- R11: `busy` is high from the cycle after an acknowledge through the load cycle, and from the cycle after an accepted exit request through the restore cycle. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_ack | output | NUM_IRQ | One-hot acknowledge of the dispatched line |
| exit_req | input | 1 | Handler exit request |
| run_env | input | 32 | Live environment register of the interrupted code |
| run_fp | input | 32 | Live frame pointer |
| run_sp | input | 32 | Live stack pointer |
| run_pc | input | 32 | Live program counter |
| rd_req | output | 1 | Vector table read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_gnt | input | 1 | Read granted; rd_data valid in the same cycle |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Dispatch or exit sequence in progress |
| ld_valid | output | 1 | Context load strobe |
| ld_restore | output | 1 | Load is a restore (1) or a handler entry (0) |
| ld_env | output | 32 | Environment to load |
| ld_fp | output | 32 | Frame pointer to load |
| ld_sp | output | 32 | Stack pointer to load |
| ld_pc | output | 32 | Program counter to load |
| mask_out | output | NUM_IRQ | Active interrupt mask |

## Verification
The acknowledge appears in the same cycle as the enabling pending pattern, so the bench drives it at a falling edge and samples 1 ns later. Each granted read is checked at the falling edge of the cycle in which its grant is high. The entry load comes one cycle after the eighth grant, and the bench waits for it edge by edge because the grants are random. The narrowed mask and the return of `busy` to low are checked one cycle after the load. A restore is due one cycle after an accepted exit request and its mask one cycle later, so the bench samples those at the following two falling edges.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  localparam int ENTRY_WORDS = 8;
  localparam int ENTRY_BYTES = 32;
  localparam logic [31:0] SP_OFFSET = 32'd16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_EXIT  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [31:0] env;
    logic [31:0] fp;
    logic [31:0] sp;
    logic [31:0] pc;
  } ctx_t;

  // byte address of word k in the entry of interrupt n
  function automatic logic [31:0] entry_word_addr(input logic [31:0] base,
                                                  input logic [31:0] irq_n,
                                                  input logic [2:0]  k);
    return base + (irq_n * ENTRY_BYTES) + {27'd0, k, 2'b00};
  endfunction

  function automatic logic [31:0] sp_from_frame(input logic [31:0] fp);
    return fp + SP_OFFSET;
  endfunction

endpackage

// File: rtl/ivd_pick.sv
module ivd_pick #(
  parameter int NUM_IRQ = 16,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic               any,
  output logic [IW-1:0]      idx,
  output logic [NUM_IRQ-1:0] onehot
);

  assign any    = |req;
  assign onehot = req & (~req + 1'b1);

  always_comb begin
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/ivd_save_stack.sv
module ivd_save_stack
  import ivd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int MW    = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  ctx_t          push_ctx,
  input  logic [MW-1:0] push_mask,
  output ctx_t          top_ctx,
  output logic [MW-1:0] top_mask,
  output logic          full,
  output logic          empty
);

  ctx_t          slot_ctx  [DEPTH];
  logic [MW-1:0] slot_mask [DEPTH];
  logic [LW-1:0] level;
  logic [LW-1:0] lvl_m1;
  logic [SW-1:0] top_idx;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign lvl_m1  = level - LW'(1);
  assign top_idx = lvl_m1[SW-1:0];
  assign top_ctx  = slot_ctx[top_idx];
  assign top_mask = slot_mask[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else if (push && !full) begin
      level <= level + LW'(1);
    end else if (pop && !empty) begin
      level <= lvl_m1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && (level == LW'(g))) begin
        slot_ctx[g]  <= push_ctx;
        slot_mask[g] <= push_mask;
      end
    end
  end

endmodule

// File: rtl/ivd_fetch.sv
module ivd_fetch
  import ivd_pkg::*;
#(
  parameter int          NUM_IRQ  = 16,
  parameter logic [31:0] VEC_BASE = 32'h0000_1000,
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam logic [2:0] LAST_W = 3'(ENTRY_WORDS - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] irq_idx,
  input  logic          rd_gnt,
  input  logic [31:0]   rd_data,
  output logic          rd_req,
  output logic [31:0]   rd_addr,
  output logic          done,
  output logic [31:0]   ent_env,
  output logic [31:0]   ent_fp,
  output logic [31:0]   ent_pc,
  output logic [31:0]   ent_mask
);

  logic          active;
  logic [2:0]    widx;
  logic [IW-1:0] num_q;

  assign rd_req  = active;
  assign rd_addr = entry_word_addr(VEC_BASE, 32'(num_q), widx);
  assign done    = active && rd_gnt && (widx == LAST_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      widx   <= '0;
      num_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      widx   <= '0;
      num_q  <= irq_idx;
    end else if (active && rd_gnt) begin
      widx <= widx + 3'd1;
      if (widx == LAST_W) active <= 1'b0;
    end
  end

  // words 4..7 (code map pointer, two parameters, reserved) are consumed
  // without being kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_env  <= '0;
      ent_fp   <= '0;
      ent_pc   <= '0;
      ent_mask <= '0;
    end else if (active && rd_gnt) begin
      case (widx)
        3'd0:    ent_env  <= rd_data;
        3'd1:    ent_fp   <= rd_data;
        3'd2:    ent_pc   <= rd_data;
        3'd3:    ent_mask <= rd_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vec_irq_dispatch.sv
module vec_irq_dispatch
  import ivd_pkg::*;
#(
  parameter int          NUM_IRQ  = 16,
  parameter int          DEPTH    = 4,
  parameter logic [31:0] VEC_BASE = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pend,
  output logic [NUM_IRQ-1:0] irq_ack,
  input  logic               exit_req,
  input  logic [31:0]        run_env,
  input  logic [31:0]        run_fp,
  input  logic [31:0]        run_sp,
  input  logic [31:0]        run_pc,
  output logic               rd_req,
  output logic [31:0]        rd_addr,
  input  logic               rd_gnt,
  input  logic [31:0]        rd_data,
  output logic               busy,
  output logic               ld_valid,
  output logic               ld_restore,
  output logic [31:0]        ld_env,
  output logic [31:0]        ld_fp,
  output logic [31:0]        ld_sp,
  output logic [31:0]        ld_pc,
  output logic [NUM_IRQ-1:0] mask_out
);

  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  seq_state_e         state;
  logic [NUM_IRQ-1:0] mask_q;
  logic [NUM_IRQ-1:0] eligible;
  logic               pick_any;
  logic [IW-1:0]      pick_idx;
  logic [NUM_IRQ-1:0] pick_oh;
  logic               stk_full, stk_empty;
  ctx_t               run_ctx, top_ctx;
  logic [NUM_IRQ-1:0] top_mask;
  logic [31:0]        ent_env, ent_fp, ent_pc, ent_mask;

  // named internal events
  logic exit_go;
  logic disp_fire;
  logic fetch_done;
  logic load_fire;
  logic restore_fire;

  assign eligible     = irq_pend & mask_q;
  assign exit_go      = (state == ST_IDLE) && exit_req && !stk_empty;
  assign disp_fire    = (state == ST_IDLE) && !exit_go && pick_any && !stk_full;
  assign load_fire    = (state == ST_LOAD);
  assign restore_fire = (state == ST_EXIT);

  assign run_ctx = '{env: run_env, fp: run_fp, sp: run_sp, pc: run_pc};

  ivd_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .req    (eligible),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  ivd_save_stack #(.DEPTH(DEPTH), .MW(NUM_IRQ)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (disp_fire),
    .pop       (restore_fire),
    .push_ctx  (run_ctx),
    .push_mask (mask_q),
    .top_ctx   (top_ctx),
    .top_mask  (top_mask),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  ivd_fetch #(.NUM_IRQ(NUM_IRQ), .VEC_BASE(VEC_BASE)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (disp_fire),
    .irq_idx  (pick_idx),
    .rd_gnt   (rd_gnt),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .done     (fetch_done),
    .ent_env  (ent_env),
    .ent_fp   (ent_fp),
    .ent_pc   (ent_pc),
    .ent_mask (ent_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (exit_go)        state <= ST_EXIT;
          else if (disp_fire) state <= ST_FETCH;
        end
        ST_FETCH: if (fetch_done) state <= ST_LOAD;
        ST_LOAD:  state <= ST_IDLE;
        ST_EXIT:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (load_fire) begin
      mask_q <= ent_mask[NUM_IRQ-1:0] & mask_q;
    end else if (restore_fire) begin
      mask_q <= top_mask;
    end
  end

  assign irq_ack    = disp_fire ? pick_oh : '0;
  assign busy       = (state != ST_IDLE);
  assign ld_valid   = load_fire || restore_fire;
  assign ld_restore = restore_fire;
  assign ld_env     = restore_fire ? top_ctx.env : ent_env;
  assign ld_fp      = restore_fire ? top_ctx.fp  : ent_fp;
  assign ld_sp      = restore_fire ? top_ctx.sp  : sp_from_frame(ent_fp);
  assign ld_pc      = restore_fire ? top_ctx.pc  : ent_pc;
  assign mask_out   = mask_q;

endmodule

// File: rtl/vec_irq_dispatch_chk.sv
module vec_irq_dispatch_chk #(
  parameter int NUM_IRQ = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic [NUM_IRQ-1:0] irq_ack,
  input logic [NUM_IRQ-1:0] mask_out,
  input logic               busy,
  input logic               ld_valid,
  input logic               ld_restore,
  input logic               rd_req,
  input logic [31:0]        rd_addr,
  input logic               rd_gnt,
  input logic               disp_fire,
  input logic               exit_go,
  input logic               fetch_done
);

  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  assert_ack_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != '0) |-> ((irq_pend & mask_out & (irq_ack - 1'b1)) == '0));

  assert_ack_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != '0) |-> ((irq_ack & ~(irq_pend & mask_out)) == '0));

  assert_no_ack_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (irq_ack == '0));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));

  assert_load_after_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (ld_valid && !ld_restore));

  assert_mask_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_restore) |=> ((mask_out & ~$past(mask_out)) == '0));

  assert_exit_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_go |=> (ld_valid && ld_restore));

  assert_busy_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> busy);

  assert_load_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> busy);

endmodule

bind vec_irq_dispatch vec_irq_dispatch_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_pend   (irq_pend),
  .irq_ack    (irq_ack),
  .mask_out   (mask_out),
  .busy       (busy),
  .ld_valid   (ld_valid),
  .ld_restore (ld_restore),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_gnt     (rd_gnt),
  .disp_fire  (disp_fire),
  .exit_go    (exit_go),
  .fetch_done (fetch_done)
);

// File: tb/vec_irq_dispatch_tb.sv
module vec_irq_dispatch_tb;

  localparam int          N    = 16;
  localparam int          DEP  = 4;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_pend = '0;
  logic [N-1:0]  irq_ack;
  logic          exit_req = 1'b0;
  logic [31:0]   run_env = '0, run_fp = '0, run_sp = '0, run_pc = '0;
  logic          rd_req;
  logic [31:0]   rd_addr;
  logic          rd_gnt = 1'b0;
  logic [31:0]   rd_data;
  logic          busy, ld_valid, ld_restore;
  logic [31:0]   ld_env, ld_fp, ld_sp, ld_pc;
  logic [N-1:0]  mask_out;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  // bench model
  int           m_depth = 0;
  logic [N-1:0] m_mask  = '1;
  logic [31:0]  s_env [DEP];
  logic [31:0]  s_fp  [DEP];
  logic [31:0]  s_sp  [DEP];
  logic [31:0]  s_pc  [DEP];
  logic [N-1:0] s_mask[DEP];
  int           exp_n = 0;
  int           exp_widx = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mask_field(input int n);
    return (32'hFFFF_FFFF << (n + 1)) & ~(32'h1 << ((n * 5 + 2) % 16));
  endfunction

  function automatic logic [31:0] tbl_word(input logic [31:0] a);
    int n;
    n = int'((a - BASE) >> 5);
    case (a[4:2])
      3'd0:    return 32'h0000_0700 | 32'(n);
      3'd1:    return 32'h0000_8000 + 32'(n) * 32'd256;
      3'd2:    return 32'h4000_0000 + 32'(n) * 32'd64;
      3'd3:    return mask_field(n);
      default: return 32'hDEAD_0000 ^ a;
    endcase
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  assign rd_data = tbl_word(rd_addr);

  vec_irq_dispatch #(.NUM_IRQ(N), .DEPTH(DEP), .VEC_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_ack(irq_ack),
    .exit_req(exit_req), .run_env(run_env), .run_fp(run_fp), .run_sp(run_sp),
    .run_pc(run_pc), .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
    .rd_data(rd_data), .busy(busy), .ld_valid(ld_valid), .ld_restore(ld_restore),
    .ld_env(ld_env), .ld_fp(ld_fp), .ld_sp(ld_sp), .ld_pc(ld_pc),
    .mask_out(mask_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // random grant, changed away from both edges
  initial begin
    void'($urandom(32'd4711));
    forever begin
      @(posedge clk);
      #2;
      rd_gnt = ($urandom_range(0, 3) != 0);
    end
  end

  // R4: each granted read address in order
  always @(negedge clk) begin
    if (rst_n && rd_req && rd_gnt) begin
      chk(rd_addr == BASE + 32'(exp_n) * 32 + 32'(exp_widx) * 4, "R4 read address",
          rd_addr, BASE + 32'(exp_n) * 32 + 32'(exp_widx) * 4);
      exp_widx++;
    end
  end

  task automatic raise(input logic [N-1:0] pend);
    logic [N-1:0] eff;
    int n;
    int waited;
    logic [N-1:0] exp_mask;
    @(negedge clk);
    irq_pend = pend;
    run_env = $urandom; run_fp = $urandom; run_sp = $urandom; run_pc = $urandom;
    #1;
    eff = pend & m_mask;
    if (m_depth < DEP && eff != '0) begin
      n = lowest(eff);
      chk(irq_ack == (N'(1) << n), "R2 ack one-hot lowest", 32'(irq_ack), 32'(N'(1) << n));
      s_env[m_depth] = run_env; s_fp[m_depth] = run_fp;
      s_sp[m_depth] = run_sp;   s_pc[m_depth] = run_pc;
      s_mask[m_depth] = m_mask;
      m_depth++;
      exp_n = n; exp_widx = 0;
      @(negedge clk);
      irq_pend = '0;
      chk(busy == 1'b1, "R11 busy after ack", 32'(busy), 32'd1);
      waited = 0;
      while (!ld_valid && waited < 300) begin
        @(negedge clk);
        waited++;
      end
      chk(ld_valid && !ld_restore, "R6 entry load strobe", {ld_valid, ld_restore}, 2'b10);
      chk(exp_widx == 8, "R4 eight reads", 32'(exp_widx), 32'd8);
      chk(ld_env == tbl_word(BASE + 32'(n) * 32), "R5 env word", ld_env,
          tbl_word(BASE + 32'(n) * 32));
      chk(ld_fp == tbl_word(BASE + 32'(n) * 32 + 4), "R6 frame base", ld_fp,
          tbl_word(BASE + 32'(n) * 32 + 4));
      chk(ld_sp == ld_fp + 32'd16, "R6 stack = frame + 16", ld_sp, ld_fp + 32'd16);
      chk(ld_pc == tbl_word(BASE + 32'(n) * 32 + 8), "R5 handler pc", ld_pc,
          tbl_word(BASE + 32'(n) * 32 + 8));
      exp_mask = N'(mask_field(n)) & m_mask;
      m_mask = exp_mask;
      @(negedge clk);
      chk(mask_out == exp_mask, "R7 narrowed mask", 32'(mask_out), 32'(exp_mask));
      chk(busy == 1'b0, "R11 busy low after load", 32'(busy), 32'd0);
    end else begin
      chk(irq_ack == '0, (m_depth == DEP) ? "R10 no ack when full" : "R3 no ack masked",
          32'(irq_ack), 32'd0);
      @(negedge clk);
      irq_pend = '0;
      chk(busy == 1'b0, "R3 stays idle", 32'(busy), 32'd0);
    end
  endtask

  task automatic leave();
    @(negedge clk);
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    if (m_depth > 0) begin
      m_depth--;
      chk(ld_valid && ld_restore, "R8 restore strobe", {ld_valid, ld_restore}, 2'b11);
      chk(busy == 1'b1, "R11 busy in restore", 32'(busy), 32'd1);
      chk(ld_env == s_env[m_depth], "R8 env restored", ld_env, s_env[m_depth]);
      chk(ld_fp == s_fp[m_depth], "R8 fp restored", ld_fp, s_fp[m_depth]);
      chk(ld_sp == s_sp[m_depth], "R8 sp restored", ld_sp, s_sp[m_depth]);
      chk(ld_pc == s_pc[m_depth], "R8 pc restored", ld_pc, s_pc[m_depth]);
      m_mask = s_mask[m_depth];
      @(negedge clk);
      chk(mask_out == m_mask, "R8 mask restored", 32'(mask_out), 32'(m_mask));
      chk(busy == 1'b0, "R11 busy low after restore", 32'(busy), 32'd0);
    end else begin
      chk(ld_valid == 1'b0, "R9 exit ignored", 32'(ld_valid), 32'd0);
      @(negedge clk);
      chk(mask_out == m_mask, "R9 mask unchanged", 32'(mask_out), 32'(m_mask));
      chk(busy == 1'b0, "R9 stays idle", 32'(busy), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && ld_valid == 0 && rd_req == 0 && irq_ack == '0, "R1 reset outputs",
        {busy, ld_valid, rd_req, |irq_ack}, 4'b0000);
    chk(mask_out == '1, "R1 reset mask", 32'(mask_out), 32'h0000_FFFF);

    raise('0);            // R3 nothing pending
    leave();              // R9 exit with empty stack
    raise(16'h0001);      // irq0
    raise(16'h0005);      // R3 both masked now
    raise(16'h0006);      // irq1 under nesting
    raise(16'h0008);      // irq3
    raise(16'h0010);      // irq4 -> 4 levels
    raise(16'hFF70);      // R10 full
    for (int i = 0; i < 5; i++) leave();

    for (int it = 0; it < 400; it++) begin
      if (m_depth > 0 && ($urandom_range(0, 2) == 0)) leave();
      else raise(N'($urandom) & N'($urandom));
    end
    while (m_depth > 0) leave();
    raise(16'h8000);      // R2 highest line alone
    leave();

    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule